// File: doc/BRIEF.md
# Header Routing Decision Unit

This block sits at the input side of a small packet switch with a configurable number of ports, from two to thirty-two. Port 0 is the switch's internal configuration port. When the first byte of a packet arrives with a valid strobe, the unit classifies that byte and decides three things: which output port the packet goes to, whether the leading byte is stripped before forwarding, and whether the packet is dropped. The decision is registered. It stays on the outputs until the consumer acknowledges it.

A header below 32 is a physical port number, and its header byte is always stripped. A header of 32 or more is a logical address that is looked up in a writable table. Each table entry holds a valid bit, a set of candidate ports and a strip flag. When an entry names several ports, the unit chooses the lowest-numbered candidate whose link is up and which is not busy. If the connected candidates are all busy, the unit holds the packet and tries again on every cycle until one of them becomes free.

Top module: `hdr_route_unit`

## Requirements
- R1: After reset `dec_valid` is 0 and every logical table entry is invalid, so every header of 32 or more is discarded until its entry has been written.
- R2: A header of 0 selects port 0 with `dec_strip` = 1.
- R3: A header from 1 to 31 that is below NPORTS selects the port of that number with `dec_strip` = 1. A header from 1 to 31 that is at or above NPORTS is discarded.
- R4: A header of 32 or more whose table entry has its valid bit clear is discarded.
- R5: A routed logical-address packet carries the strip flag stored in its entry: 1 strips the header and 0 keeps it.
- R6: A logical-address packet goes to the lowest-numbered port that is set in the entry's candidate mask (bit i = port i), has `link_up` = 1 and has `port_busy` = 0.
- R7: If none of an entry's candidates has its link up, the packet is discarded.
- R8: If at least one candidate is connected but all connected candidates are busy, no decision is issued. The lookup is repeated on every cycle, and the decision appears one cycle after a candidate becomes free.
- R9: A decision that can be resolved at once appears with `dec_valid` = 1 on the clock edge after the one that samples `hdr_valid`. All decision outputs stay unchanged until the edge that samples `dec_ack`, and `dec_valid` is 0 after that edge.
- R10: `hdr_valid` is ignored while a decision is held or pending. Such a header changes no output and produces no later decision.
- R11: A table write (`tbl_wr_en`, entry selected by `tbl_wr_addr`, `tbl_wr_valid` = 0 invalidates the entry) takes effect from the next cycle. A lookup in the same cycle uses the old contents. Writes to addresses below 32 are ignored.
- R12: A discard is reported as `dec_valid` = 1 and `dec_discard` = 1 with `dec_port` = 0 and `dec_strip` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_valid | input | 1 | Header byte strobe |
| hdr_byte | input | HDR_W | First byte of the packet |
| link_up | input | NPORTS | Per-port link connected |
| port_busy | input | NPORTS | Per-port output occupied |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | HDR_W | Logical address to write |
| tbl_wr_valid | input | 1 | Valid bit written into the entry |
| tbl_wr_ports | input | NPORTS | Candidate port mask written |
| tbl_wr_strip | input | 1 | Strip flag written |
| dec_ack | input | 1 | Consumer accepts the held decision |
| dec_valid | output | 1 | Decision present |
| dec_port | output | PW | Selected output port |
| dec_strip | output | 1 | Remove leading byte |
| dec_discard | output | 1 | Packet is dropped |

## Verification
Two functions can coincide in one cycle: a table write and a header lookup, both aimed at the same logical address. The bench provokes this by raising `hdr_valid` and `tbl_wr_en` on the same edge for an entry that has not been configured. The correct result is a discard, since the lookup sees the old contents, and a second lookup must then route by the new entry. The same overlap arises while a grouped lookup is waiting. To cover it, the bench sweeps every combination of link and busy flags and releases the busy ports in the middle of a wait, then checks that the retried lookup picks the lowest free connected candidate.

// File: rtl/hdr_route_pkg.sv
package hdr_route_pkg;
   // controller state: accepting, retrying a stalled group, presenting
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_HOLD = 2'd2
   } rt_state_e;

   // outcome of one resolution attempt
   typedef enum logic [1:0] {
      RES_ROUTE = 2'd0,
      RES_DROP  = 2'd1,
      RES_STALL = 2'd2
   } rt_res_e;
endpackage

// File: rtl/hdr_route_table.sv
module hdr_route_table #(
   parameter int NPORTS  = 4,
   parameter int LA_BASE = 32,
   parameter int HDR_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [HDR_W-1:0]  wr_addr,
   input  logic              wr_valid,
   input  logic [NPORTS-1:0] wr_ports,
   input  logic              wr_strip,
   input  logic [HDR_W-1:0]  rd_addr,
   output logic              rd_hit,
   output logic [NPORTS-1:0] rd_ports,
   output logic              rd_strip
);
   localparam int TOP_A = (1 << HDR_W) - 1;

   logic [TOP_A:LA_BASE] ent_vld;
   logic [TOP_A:LA_BASE] ent_strip;
   logic [NPORTS-1:0]    ent_ports [LA_BASE:TOP_A];

   logic wr_hit;
   assign wr_hit = wr_en && (wr_addr >= HDR_W'(LA_BASE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_vld <= '0;
      else if (wr_hit) ent_vld[wr_addr] <= wr_valid;
   end

   always_ff @(posedge clk) begin
      if (wr_hit) begin
         ent_ports[wr_addr] <= wr_ports;
         ent_strip[wr_addr] <= wr_strip;
      end
   end

   always_comb begin
      rd_hit   = 1'b0;
      rd_ports = '0;
      rd_strip = 1'b0;
      if (rd_addr >= HDR_W'(LA_BASE)) begin
         rd_hit   = ent_vld[rd_addr];
         rd_ports = ent_ports[rd_addr];
         rd_strip = ent_strip[rd_addr];
      end
   end
endmodule

// File: rtl/hdr_route_pick.sv
module hdr_route_pick #(
   parameter int NPORTS = 4,
   parameter int PW     = 2
) (
   input  logic [NPORTS-1:0] cand,
   input  logic [NPORTS-1:0] link,
   input  logic [NPORTS-1:0] busy,
   output logic              any_conn,
   output logic              found,
   output logic [PW-1:0]     idx
);
   logic [NPORTS-1:0] free_v;
   logic [NPORTS-1:0] below_v;
   logic [NPORTS-1:0] first_v;

   assign free_v   = cand & link & ~busy;
   assign any_conn = |(cand & link);
   assign found    = |free_v;

   assign below_v[0] = 1'b0;
   genvar g;
   generate
      for (g = 1; g < NPORTS; g++) begin : g_chain
         assign below_v[g] = below_v[g-1] | free_v[g-1];
      end
      for (g = 0; g < NPORTS; g++) begin : g_first
         assign first_v[g] = free_v[g] & ~below_v[g];
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < NPORTS; i++)
         if (first_v[i]) idx = idx | PW'(i);
   end
endmodule

// File: rtl/hdr_route_unit.sv
module hdr_route_unit #(
   parameter int NPORTS  = 4,
   parameter int LA_BASE = 32,
   parameter int HDR_W   = 8,
   localparam int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_valid,
   input  logic [HDR_W-1:0]  hdr_byte,
   input  logic [NPORTS-1:0] link_up,
   input  logic [NPORTS-1:0] port_busy,
   input  logic              tbl_wr_en,
   input  logic [HDR_W-1:0]  tbl_wr_addr,
   input  logic              tbl_wr_valid,
   input  logic [NPORTS-1:0] tbl_wr_ports,
   input  logic              tbl_wr_strip,
   input  logic              dec_ack,
   output logic              dec_valid,
   output logic [PW-1:0]     dec_port,
   output logic              dec_strip,
   output logic              dec_discard
);
   import hdr_route_pkg::*;

   generate
      if (NPORTS < 2 || NPORTS > 32) begin : g_bad_ports
         $error("hdr_route_unit: NPORTS must lie in 2..32");
      end
      if (LA_BASE < NPORTS || LA_BASE >= (1 << HDR_W)) begin : g_bad_base
         $error("hdr_route_unit: LA_BASE out of range");
      end
   endgenerate

   rt_state_e         state;
   logic [HDR_W-1:0]  held_hdr;
   logic [HDR_W-1:0]  cur_hdr;
   logic              tbl_hit;
   logic [NPORTS-1:0] tbl_ports;
   logic              tbl_strip;
   logic              pick_conn;
   logic              pick_found;
   logic [PW-1:0]     pick_idx;
   rt_res_e           res;
   logic [PW-1:0]     res_port;
   logic              res_strip;
   logic              eval_now;

   // fresh header while idle, held header while retrying
   assign cur_hdr  = (state == ST_IDLE) ? hdr_byte : held_hdr;
   assign eval_now = ((state == ST_IDLE) && hdr_valid) || (state == ST_WAIT);

   hdr_route_table #(.NPORTS(NPORTS), .LA_BASE(LA_BASE), .HDR_W(HDR_W)) tbl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_wr_en),
      .wr_addr  (tbl_wr_addr),
      .wr_valid (tbl_wr_valid),
      .wr_ports (tbl_wr_ports),
      .wr_strip (tbl_wr_strip),
      .rd_addr  (cur_hdr),
      .rd_hit   (tbl_hit),
      .rd_ports (tbl_ports),
      .rd_strip (tbl_strip)
   );

   hdr_route_pick #(.NPORTS(NPORTS), .PW(PW)) pick_i (
      .cand     (tbl_ports),
      .link     (link_up),
      .busy     (port_busy),
      .any_conn (pick_conn),
      .found    (pick_found),
      .idx      (pick_idx)
   );

   always_comb begin
      res       = RES_DROP;
      res_port  = '0;
      res_strip = 1'b0;
      if (cur_hdr < HDR_W'(LA_BASE)) begin
         if (cur_hdr < HDR_W'(NPORTS)) begin
            res       = RES_ROUTE;
            res_port  = cur_hdr[PW-1:0];
            res_strip = 1'b1;
         end
      end else if (tbl_hit && pick_conn) begin
         if (pick_found) begin
            res       = RES_ROUTE;
            res_port  = pick_idx;
            res_strip = tbl_strip;
         end else begin
            res = RES_STALL;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         held_hdr    <= '0;
         dec_valid   <= 1'b0;
         dec_port    <= '0;
         dec_strip   <= 1'b0;
         dec_discard <= 1'b0;
      end else begin
         if ((state == ST_IDLE) && hdr_valid) held_hdr <= hdr_byte;
         if (eval_now) begin
            if (res == RES_STALL) begin
               state <= ST_WAIT;
            end else begin
               state       <= ST_HOLD;
               dec_valid   <= 1'b1;
               dec_port    <= res_port;
               dec_strip   <= res_strip;
               dec_discard <= (res == RES_DROP);
            end
         end else if ((state == ST_HOLD) && dec_ack) begin
            state       <= ST_IDLE;
            dec_valid   <= 1'b0;
            dec_port    <= '0;
            dec_strip   <= 1'b0;
            dec_discard <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hdr_route_chk.sv
module hdr_route_chk #(
   parameter int NPORTS = 4,
   parameter int PW     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dec_valid,
   input logic              dec_ack,
   input logic [PW-1:0]     dec_port,
   input logic              dec_strip,
   input logic              dec_discard,
   input logic [NPORTS-1:0] cand,
   input logic [NPORTS-1:0] link,
   input logic [NPORTS-1:0] busy,
   input logic              found,
   input logic [PW-1:0]     idx
);
   logic [NPORTS-1:0] lower_m;
   always_comb begin
      lower_m = '0;
      for (int i = 0; i < NPORTS; i++)
         if (PW'(i) < idx) lower_m[i] = 1'b1;
   end

   // R9: held decision does not move before acknowledge
   a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && !dec_ack |=> dec_valid && $stable(dec_port)
                                && $stable(dec_strip) && $stable(dec_discard));

   // R9: acknowledge releases the decision
   a_r9_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && dec_ack |=> !dec_valid);

   // R12: a discard carries no port and no strip
   a_r12_discard_clean: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && dec_discard |-> (dec_port == '0) && !dec_strip);

   // R6: the picked port is a free connected candidate
   a_r6_pick_free: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> cand[idx] && link[idx] && !busy[idx]);

   // R6: no free connected candidate below the picked one
   a_r6_pick_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> ((cand & link & ~busy & lower_m) == '0));
endmodule

bind hdr_route_unit hdr_route_chk #(.NPORTS(NPORTS), .PW(PW)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .dec_valid   (dec_valid),
   .dec_ack     (dec_ack),
   .dec_port    (dec_port),
   .dec_strip   (dec_strip),
   .dec_discard (dec_discard),
   .cand        (tbl_ports),
   .link        (link_up),
   .busy        (port_busy),
   .found       (pick_found),
   .idx         (pick_idx)
);

// File: tb/hdr_route_unit_tb.sv
module hdr_route_unit_tb_top;
   localparam int NP = 4;
   localparam int PWB = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hdr_valid = 1'b0;
   logic [7:0] hdr_byte = '0;
   logic [NP-1:0] link_up = '1;
   logic [NP-1:0] port_busy = '0;
   logic tbl_wr_en = 1'b0;
   logic [7:0] tbl_wr_addr = '0;
   logic tbl_wr_valid = 1'b0;
   logic [NP-1:0] tbl_wr_ports = '0;
   logic tbl_wr_strip = 1'b0;
   logic dec_ack = 1'b0;
   logic dec_valid;
   logic [PWB-1:0] dec_port;
   logic dec_strip;
   logic dec_discard;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   hdr_route_unit #(.NPORTS(NP), .LA_BASE(32), .HDR_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte),
      .link_up(link_up), .port_busy(port_busy), .tbl_wr_en(tbl_wr_en),
      .tbl_wr_addr(tbl_wr_addr), .tbl_wr_valid(tbl_wr_valid),
      .tbl_wr_ports(tbl_wr_ports), .tbl_wr_strip(tbl_wr_strip),
      .dec_ack(dec_ack), .dec_valid(dec_valid), .dec_port(dec_port),
      .dec_strip(dec_strip), .dec_discard(dec_discard));

   function automatic int pk(bit v, bit d, int p, bit s);
      return (int'(v) << 4) | (int'(d) << 3) | (p << 1) | int'(s);
   endfunction

   function automatic int obs();
      return pk(dec_valid, dec_discard, int'(dec_port), dec_strip);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tbl_write(input int a, input bit v, input int m, input bit s);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_addr = 8'(a); tbl_wr_valid = v;
      tbl_wr_ports = NP'(m); tbl_wr_strip = s;
      @(negedge clk);
      tbl_wr_en = 1'b0;
   endtask

   // strobe a header; return at the negedge after the sampling edge
   task automatic send(input int h);
      @(negedge clk);
      hdr_valid = 1'b1; hdr_byte = 8'(h);
      @(negedge clk);
      hdr_valid = 1'b0;
   endtask

   task automatic ack();
      dec_ack = 1'b1;
      @(negedge clk);
      dec_ack = 1'b0;
   endtask

   int expv;
   int frozen;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset outputs", obs(), 0);

      // exhaustive header sweep on empty table
      for (int h = 0; h < 256; h++) begin
         send(h);
         if (h == 0) begin
            expv = pk(1, 0, 0, 1);
            chk("R2", $sformatf("hdr %0d", h), obs(), expv);
         end else if (h < NP) begin
            expv = pk(1, 0, h, 1);
            chk("R3", $sformatf("hdr %0d", h), obs(), expv);
         end else if (h < 32) begin
            expv = pk(1, 1, 0, 0);
            chk("R3", $sformatf("hdr %0d", h), obs(), expv);
         end else begin
            expv = pk(1, 1, 0, 0);
            chk("R4", $sformatf("hdr %0d after R1 reset", h), obs(), expv);
         end
         ack();
         if (h == 5) chk("R9", "released after ack", obs(), 0);
      end

      // single-target entries with both strip settings
      tbl_write(60, 1, 'b1000, 1);
      tbl_write(75, 1, 'b0100, 0);
      send(60); chk("R5", "entry 60 strips", obs(), pk(1, 0, 3, 1)); ack();
      send(75); chk("R5", "entry 75 keeps", obs(), pk(1, 0, 2, 0)); ack();

      // writes below the logical range are ignored
      tbl_write(10, 1, 'b0100, 0);
      send(10); chk("R11", "write to hdr 10 ignored", obs(), pk(1, 1, 0, 0)); ack();
      tbl_write(2, 1, 'b0001, 0);
      send(2); chk("R11", "write to hdr 2 ignored", obs(), pk(1, 0, 2, 1)); ack();

      // grouped entry: all link/busy combinations
      tbl_write(50, 1, 'b1110, 1);
      for (int l = 0; l < 16; l++) begin
         for (int b = 0; b < 16; b++) begin
            int av; int fr; int lo;
            av = l & 'b1110;
            fr = av & ~b;
            link_up = NP'(l); port_busy = NP'(b);
            send(50);
            if (av == 0) begin
               chk("R7", $sformatf("l=%0d b=%0d", l, b), obs(), pk(1, 1, 0, 0));
            end else if (fr == 0) begin
               chk("R8", $sformatf("stall l=%0d b=%0d", l, b), obs(), 0);
               @(negedge clk);
               chk("R8", $sformatf("still stalled l=%0d b=%0d", l, b), obs(), 0);
               port_busy = '0;
               @(negedge clk);
               lo = 0;
               for (int k = NP - 1; k >= 0; k--) if (av[k]) lo = k;
               chk("R8", $sformatf("retry l=%0d b=%0d", l, b), obs(), pk(1, 0, lo, 1));
            end else begin
               lo = 0;
               for (int k = NP - 1; k >= 0; k--) if (fr[k]) lo = k;
               chk("R6", $sformatf("l=%0d b=%0d", l, b), obs(), pk(1, 0, lo, 1));
            end
            ack();
         end
      end
      link_up = '1; port_busy = '0;

      // hold stability and ignored header while held
      send(60);
      frozen = obs();
      chk("R9", "decision after one edge", frozen, pk(1, 0, 3, 1));
      hdr_valid = 1'b1; hdr_byte = 8'd75;
      link_up = 4'b0001; port_busy = 4'b1000;
      tbl_wr_en = 1'b1; tbl_wr_addr = 8'd60; tbl_wr_valid = 1'b0;
      tbl_wr_ports = '0; tbl_wr_strip = 1'b0;
      @(negedge clk);
      tbl_wr_en = 1'b0;
      chk("R10", "held with header strobe", obs(), frozen);
      @(negedge clk);
      chk("R9", "held two cycles", obs(), frozen);
      hdr_valid = 1'b0;
      link_up = '1; port_busy = '0;
      ack();
      chk("R9", "cleared by ack", obs(), 0);
      @(negedge clk);
      chk("R10", "no queued decision", obs(), 0);
      send(60); chk("R11", "invalidated entry", obs(), pk(1, 1, 0, 0)); ack();

      // write and lookup of the same entry in one cycle
      @(negedge clk);
      hdr_valid = 1'b1; hdr_byte = 8'd90;
      tbl_wr_en = 1'b1; tbl_wr_addr = 8'd90; tbl_wr_valid = 1'b1;
      tbl_wr_ports = 4'b0001; tbl_wr_strip = 1'b0;
      @(negedge clk);
      hdr_valid = 1'b0; tbl_wr_en = 1'b0;
      chk("R11", "same-cycle lookup sees old", obs(), pk(1, 1, 0, 0));
      ack();
      send(90); chk("R11", "next lookup sees new", obs(), pk(1, 0, 0, 0)); ack();

      // entry invalidated while a lookup waits
      tbl_write(50, 1, 'b0110, 1);
      port_busy = 4'b0110;
      send(50); chk("R8", "waiting", obs(), 0);
      tbl_wr_en = 1'b1; tbl_wr_addr = 8'd50; tbl_wr_valid = 1'b0;
      @(negedge clk);
      tbl_wr_en = 1'b0;
      @(negedge clk);
      chk("R12", "drop after invalidation while waiting", obs(), pk(1, 1, 0, 0));
      ack();
      port_busy = '0;

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule